// File: doc/BRIEF.md
# Conditional Jump Decoder

This block looks at one 32-bit control word and the current 8-bit program counter and decides where the sequencer goes next. If the word is a jump and its condition holds against the sign, zero, carry and T0 flags, the next program counter is the 8-bit target carried in the word. In every other case the counter moves on by one and wraps from 255 to 0.

The decode path is purely combinational, so the decision belongs to the same cycle in which the word is presented. A qualifier input marks the cycles that carry a real word. When the qualifier is low the counter is held. The other instruction classes (arithmetic, immediate move, transfer, loop and end) are only told apart from a jump, so that none of them can cause a jump. Their execution is handled elsewhere. The clock and the synchronous active-high reset are used only by the checking logic that sits next to the decode.

Top module: `jmp_decode_top`

## Requirements
- R1: A word is a jump only when `instr_valid` is 1, bits 31:30 equal 3 and bits 29:28 equal 1. Any other word never asserts `jump_taken`, and `pc_next` is `pc_cur`+1.
- R2: When `jump_taken` is 1, `pc_next` equals bits 7:0 of the word.
- R3: A jump whose bits 25:19 are all zero is always taken, whatever the flags.
- R4: Bit 24 sets the polarity of a conditional jump. When it is 1 the jump is taken if the selected condition is true. When it is 0 the jump is taken if the condition is false.
- R5: Bits 22:19 select the condition: 1 tests Z, 2 tests S, 3 tests Z OR S, 4 tests C, 8 tests T0.
- R6: A conditional jump with any other selector value is never taken, for either polarity.
- R7: When a valid word is not taken, `pc_next` is `pc_cur`+1 modulo 256, so 255 goes to 0.
- R8: While `instr_valid` is 0, `jump_taken` is 0 and `pc_next` equals `pc_cur`.
- R9: Bits 25 and 23 count only toward the all-zero test of R3. In a conditional jump they do not change the result.
- R10: While `rst` is held, with `instr_valid` at 0, `jump_taken` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the checking logic |
| rst | input | 1 | Synchronous active-high reset for the checks |
| instr_valid | input | 1 | Marks a cycle that carries a real instruction word |
| instr | input | 32 | Instruction word |
| pc_cur | input | 8 | Current program counter |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_t0 | input | 1 | T0 flag |
| jump_taken | output | 1 | The jump is taken in this cycle |
| pc_next | output | 8 | Program counter for the following cycle |

## Verification
The properties assume that the word, the counter and the flags are stable and free of unknown values at each rising edge once reset is released, because they sample the combinational outputs there. The bench meets this by changing inputs only on falling edges, by holding `instr_valid` low throughout reset, and by comparing the outputs one nanosecond after each change. Every selector value, both polarities and all sixteen flag combinations are driven with known values, so no check depends on a value left over from before.

// File: rtl/jmp_decode_pkg.sv
package jmp_decode_pkg;

    localparam int WORD_W   = 32;
    localparam int PC_W     = 8;
    localparam int SEL_W    = 4;

    // Bit positions that the decode depends on
    localparam int CLS_HI   = 31;
    localparam int SUB_HI   = 29;
    localparam int END_BIT  = 27;
    localparam int COND_HI  = 25;
    localparam int COND_LO  = 19;
    localparam int POL_BIT  = 24;
    localparam int SEL_LO   = 19;

    localparam logic [1:0] CLS_CTRL = 2'd3;
    localparam logic [1:0] SUB_JUMP = 2'd1;

    typedef enum logic [2:0] {
        K_ARITH,
        K_RSVD,
        K_IMM,
        K_XFER,
        K_JUMP,
        K_LOOP,
        K_END,
        K_CTRL_RSVD
    } word_kind_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic t0;
    } flag_set_t;

    typedef struct packed {
        logic              always_go;
        logic              want_true;
        logic [SEL_W-1:0]  sel;
    } cond_fields_t;

    function automatic cond_fields_t split_cond(input logic [WORD_W-1:0] w);
        cond_fields_t f;
        f.always_go = (w[COND_HI:COND_LO] == '0);
        f.want_true = w[POL_BIT];
        f.sel       = w[SEL_LO +: SEL_W];
        return f;
    endfunction

endpackage

// File: rtl/jmp_kind_decode.sv
module jmp_kind_decode
    import jmp_decode_pkg::*;
(
    input  logic [3:0]  top_bits,   // word bits 31:28
    input  logic        end_bit,    // word bit 27
    output word_kind_e  kind,
    output logic        is_jump
);
    always_comb begin
        unique case (top_bits[3:2])
            2'd0: kind = K_ARITH;
            2'd1: kind = K_RSVD;
            2'd2: kind = K_IMM;
            default: begin
                unique case (top_bits[1:0])
                    2'd0:    kind = K_XFER;
                    2'd1:    kind = K_JUMP;
                    2'd2:    kind = end_bit ? K_LOOP : K_END;
                    default: kind = K_CTRL_RSVD;
                endcase
            end
        endcase
    end

    assign is_jump = (kind == K_JUMP);
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_decode_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cond_fields_t  cf,
    input  flag_set_t     fl,
    output logic          cond_ok
);
    logic known;
    logic truth;

    always_comb begin
        known = 1'b1;
        unique case (cf.sel)
            4'd1:    truth = fl.z;
            4'd2:    truth = fl.s;
            4'd3:    truth = fl.z | fl.s;
            4'd4:    truth = fl.c;
            4'd8:    truth = fl.t0;
            default: begin
                truth = 1'b0;
                known = 1'b0;
            end
        endcase
    end

    assign cond_ok = cf.always_go | (known & (truth == cf.want_true));

    // R6: unlisted selector never passes
    p_unlisted_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (!cf.always_go && !(cf.sel inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd8})) |-> !cond_ok);

    // R5: the combined code passes with either flag when polarity is true
    p_zs_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (!cf.always_go && cf.sel == 4'd3 && cf.want_true && (fl.z || fl.s)) |-> cond_ok);
endmodule

// File: rtl/jmp_pc_step.sv
module jmp_pc_step
    import jmp_decode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             take,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  pc_cur,
    output logic [PC_W-1:0]  pc_next
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    always_comb begin
        if (!valid)
            pc_next = pc_cur;
        else if (take)
            pc_next = target;
        else
            pc_next = pc_cur + ONE;
    end

    // R7: advance wraps at the top of the counter
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && !take && pc_cur == '1) |-> (pc_next == '0));

    // R8: no movement without a valid word
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (pc_next == pc_cur));
endmodule

// File: rtl/jmp_decode_top.sv
module jmp_decode_top
    import jmp_decode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [7:0]       pc_cur,
    input  logic             flag_s,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic             flag_t0,
    output logic             jump_taken,
    output logic [7:0]       pc_next
);
    word_kind_e    kind;
    logic          is_jump;
    cond_fields_t  cf;
    flag_set_t     fl;
    logic          cond_ok;

    // Bits outside the fields decoded here
    logic unused_bits;
    assign unused_bits = ^{instr[18:8], instr[26], kind};

    jmp_kind_decode u_kind (
        .top_bits (instr[CLS_HI:SUB_HI-1]),
        .end_bit  (instr[END_BIT]),
        .kind     (kind),
        .is_jump  (is_jump)
    );

    assign cf = split_cond(instr);
    assign fl = '{z: flag_z, s: flag_s, c: flag_c, t0: flag_t0};

    jmp_cond_eval u_cond (
        .clk     (clk),
        .rst     (rst),
        .cf      (cf),
        .fl      (fl),
        .cond_ok (cond_ok)
    );

    assign jump_taken = instr_valid & is_jump & cond_ok;

    jmp_pc_step u_step (
        .clk     (clk),
        .rst     (rst),
        .valid   (instr_valid),
        .take    (jump_taken),
        .target  (instr[PC_W-1:0]),
        .pc_cur  (pc_cur),
        .pc_next (pc_next)
    );

    // R1: only the jump opcode can be taken
    p_only_jump_r1: assert property (@(posedge clk) disable iff (rst)
        (instr[31:30] != CLS_CTRL || instr[29:28] != SUB_JUMP) |-> !jump_taken);

    // R2: a taken jump lands on the target byte
    p_target_r2: assert property (@(posedge clk) disable iff (rst)
        jump_taken |-> (pc_next == instr[7:0]));

    // R3: empty condition field always jumps
    p_uncond_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[31:28] == 4'hD && instr[25:19] == 7'd0) |-> jump_taken);

    // R8: no jump without a valid word
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !jump_taken);
endmodule

// File: tb/sim_jmp_decode_top.sv
module sim_jmp_decode_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [7:0]  pc_cur = '0;
    logic        flag_s = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_t0 = 1'b0;
    logic        jump_taken;
    logic [7:0]  pc_next;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    jmp_decode_top u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .pc_cur(pc_cur), .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c),
        .flag_t0(flag_t0), .jump_taken(jump_taken), .pc_next(pc_next)
    );

    // Expected values from the requirements
    function automatic logic [8:0] model(input logic v, input logic [31:0] w,
                                         input logic [7:0] pc, input logic [3:0] f);
        // f = {s, z, c, t0}
        logic tk;
        logic hit;
        logic ok;
        tk = 1'b0;
        if (!v) return {1'b0, pc};
        if (w[31:28] == 4'b1101) begin
            if (w[25:19] == 7'd0) tk = 1'b1;
            else begin
                ok = 1'b1;
                case (w[22:19])
                    4'd1: hit = f[2];
                    4'd2: hit = f[3];
                    4'd3: hit = f[2] | f[3];
                    4'd4: hit = f[1];
                    4'd8: hit = f[0];
                    default: begin hit = 1'b0; ok = 1'b0; end
                endcase
                tk = ok && (hit == w[24]);
            end
        end
        return tk ? {1'b1, w[7:0]} : {1'b0, pc + 8'd1};
    endfunction

    task automatic apply_check(input string req, input logic v, input logic [31:0] w,
                               input logic [7:0] pc, input logic [3:0] f);
        logic [8:0] exp;
        @(negedge clk);
        instr_valid = v; instr = w; pc_cur = pc;
        {flag_s, flag_z, flag_c, flag_t0} = f;
        #1;
        exp = model(v, w, pc, f);
        checks++;
        if ({jump_taken, pc_next} !== exp) begin
            failures++;
            $display("FAIL %s: taken/pc actual=%b/%02h expected=%b/%02h (w=%08h pc=%02h f=%b)",
                     req, jump_taken, pc_next, exp[8], exp[7:0], w, pc, f);
        end
    endtask

    function automatic logic [31:0] jw(input logic [6:0] cond, input logic [7:0] tgt);
        return {4'b1101, 2'b00, cond, 11'h2A5, tgt};
    endfunction

    task automatic t_reset();
        @(negedge clk); #1;
        checks++;
        if (jump_taken !== 1'b0 || pc_next !== 8'h00) begin
            failures++;
            $display("FAIL R10: actual=%b/%02h expected=0/00", jump_taken, pc_next);
        end
    endtask

    task automatic t_classes();
        // R1: other classes, each with jump-like low fields
        apply_check("R1", 1'b1, 32'h0000_0012, 8'h10, 4'hF);
        apply_check("R1", 1'b1, 32'h4000_0034, 8'h20, 4'h0);
        apply_check("R1", 1'b1, 32'h8000_0056, 8'h30, 4'hF);
        apply_check("R1", 1'b1, 32'hC000_0078, 8'h40, 4'hF);
        apply_check("R1", 1'b1, 32'hE800_0099, 8'h50, 4'hF);
        apply_check("R1", 1'b1, 32'hE000_0099, 8'h51, 4'hF);
        apply_check("R1", 1'b1, 32'hF000_00AB, 8'h60, 4'h0);
    endtask

    task automatic t_uncond();
        for (int f = 0; f < 16; f++)
            apply_check("R3", 1'b1, jw(7'd0, 8'(8'hC0 + f)), 8'h05, 4'(f));
        apply_check("R2", 1'b1, jw(7'd0, 8'hFF), 8'h00, 4'h0);
    endtask

    task automatic t_codes();
        logic [3:0] sels [5] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd8};
        for (int i = 0; i < 5; i++)
            for (int p = 0; p < 2; p++)
                for (int f = 0; f < 16; f++)
                    apply_check(p ? "R4/R5 true" : "R4/R5 false", 1'b1,
                                jw({1'b0, 1'(p), 1'b0, sels[i]}, 8'(8'h80 + f)),
                                8'(8'h40 + i), 4'(f));
    endtask

    task automatic t_unknown();
        for (int s = 0; s < 16; s++)
            if (!(s inside {1, 2, 3, 4, 8}))
                for (int p = 0; p < 2; p++)
                    apply_check("R6", 1'b1, jw({1'b0, 1'(p), 1'b0, 4'(s)}, 8'h77),
                                8'h33, 4'hF);
        apply_check("R6", 1'b1, jw(7'b0100000, 8'h77), 8'h33, 4'h0);
    endtask

    task automatic t_wrap();
        apply_check("R7", 1'b1, 32'h0000_0000, 8'hFF, 4'h0);
        apply_check("R7", 1'b1, jw(7'b0100001, 8'h12), 8'hFF, 4'h0);
        apply_check("R2", 1'b1, jw(7'b0100001, 8'h12), 8'hFF, 4'b0100);
    endtask

    task automatic t_invalid();
        apply_check("R8", 1'b0, jw(7'd0, 8'h99), 8'h5A, 4'hF);
        apply_check("R8", 1'b0, 32'h0000_0000, 8'hFF, 4'h0);
    endtask

    task automatic t_extra_bits();
        for (int e = 1; e < 4; e++)
            for (int f = 0; f < 16; f++)
                apply_check("R9", 1'b1, jw({e[1], 1'b1, e[0], 4'd4}, 8'h6C), 8'h21, 4'(f));
        apply_check("R9", 1'b1, jw(7'b1000000, 8'h6C), 8'h21, 4'h0);
        apply_check("R9", 1'b1, jw(7'b0010000, 8'h6C), 8'h21, 4'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_classes();
        t_uncond();
        t_codes();
        t_unknown();
        t_wrap();
        t_invalid();
        t_extra_bits();
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule